// File: doc/BRIEF.md
# Battery Dip Attenuation Controller

This block watches a battery-voltage code and, when the battery sags below a programmable level, requests extra gain reduction on a fast, priority path. Its attenuation grows in programmable steps at a programmable interval. When the battery recovers, the attenuation is held for a programmable time and then unwound at the release interval that the level limiter also uses. Its request and the limiter's request are added together under a single shared ceiling, so the two never reduce gain by more than the common maximum.

Two options change what happens after a dip. The first raises a sticky power-down request that stays until the device passes through an off state. The second freezes the attenuation in hold after recovery until a one-cycle clear pulse arrives or the device is muted. Timing is derived from a one-microsecond strobe. All attenuation values are in half-decibel units.

Top module: `bop_ctrl`

## Requirements
- R1: The battery code and the threshold code use the same scale: 4.5 V plus 25 mV per code. A dip means `vbat_code < thr_code`, so equality is not a dip.
- R2: When the controller is enabled, not powered down and has headroom, a dip adds the first step on the first rising clock edge at which the dip is sampled, well inside 10 µs.
- R3: While the dip lasts, a further step is added every 5·2^`atk_rate` microsecond ticks. The step code 0, 1, 2 or 3 gives 1, 2, 3 or 4 half-dB units.
- R4: The cap is `cap_code`+2 half-dB units. `att_total` equals `lim_att`+`bop_att` limited to the cap. Attack stops adding once `lim_att`+`bop_att` reaches the cap.
- R5: After recovery, `bop_att` stays constant for the hold time. `hold_sel` 0 to 7 selects 0, 10, 25, 50, 100, 250, 500 or 1000 ms. Release then removes one half-dB unit per release period. `rls_rate` 0 to 7 selects 10, 50, 100, 250, 500, 750, 1000 or 1500 ms, and one ms is `TICKS_PER_MS` ticks.
- R6: `evt_flag` rises when the attack starts. It stays high while `bop_att` is non-zero and falls when release reaches zero.
- R7: A new dip during hold or release restarts the attack at once, and a step is added on the same edge.
- R8: With `en` low, `bop_att` is 0 and `att_total` equals `lim_att`. No limiter enable affects the controller.
- R9: With `sd_on_evt` set, an attack start raises `sd_req`. The request stays high until `dev_off` is seen. `dev_off` also clears the attenuation and the event flag.
- R10: With `inf_hold` set, hold never times out. A one-cycle `hold_clr` pulse or a high `mute` ends the hold, and release then follows the normal release timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| en | input | 1 | Controller enable |
| vbat_code | input | 8 | Battery voltage code |
| thr_code | input | 8 | Dip threshold code |
| atk_rate | input | 3 | Attack interval select |
| atk_step | input | 2 | Attack step select |
| hold_sel | input | 3 | Hold time select |
| rls_rate | input | 3 | Release interval select (shared with limiter) |
| cap_code | input | 5 | Shared attenuation ceiling code |
| lim_att | input | 6 | Limiter attenuation, half-dB units |
| sd_on_evt | input | 1 | Request power-down on a dip |
| inf_hold | input | 1 | Hold until cleared |
| hold_clr | input | 1 | One-cycle hold clear pulse |
| mute | input | 1 | Device muted |
| dev_off | input | 1 | Device in off state |
| att_total | output | 7 | Combined attenuation, half-dB units |
| bop_att | output | 6 | Dip-path attenuation, half-dB units |
| sd_req | output | 1 | Sticky power-down request |
| evt_flag | output | 1 | Dip event in progress |

## Verification
The properties assume that the battery code, the configuration and the limiter value are synchronous to `clk` and change only between edges. They also assume that `lim_att` may take any value, including values above the cap. No property relies on `us_tick` arriving at a regular rate, because the attack-latency and monotonic-growth checks look only at single edges. The stimulus changes every input on the falling clock edge, holds `us_tick` high so that intervals count whole cycles, and sets the timescale through `TICKS_PER_MS` so that hold and release windows stay short.

// File: rtl/bop_pkg.sv
package bop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ATTACK  = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RELEASE = 2'd3
  } bop_state_e;

  // hold duration in milliseconds
  function automatic int unsigned hold_ms(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 10;
      3'd2:    return 25;
      3'd3:    return 50;
      3'd4:    return 100;
      3'd5:    return 250;
      3'd6:    return 500;
      default: return 1000;
    endcase
  endfunction

  // release period per half-dB unit in milliseconds
  function automatic int unsigned rls_ms(input logic [2:0] sel);
    case (sel)
      3'd0:    return 10;
      3'd1:    return 50;
      3'd2:    return 100;
      3'd3:    return 250;
      3'd4:    return 500;
      3'd5:    return 750;
      3'd6:    return 1000;
      default: return 1500;
    endcase
  endfunction

  // a counter loaded with n-1 fires on the n-th tick
  function automatic int unsigned less_one(input int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

endpackage

// File: rtl/bop_timer.sv
module bop_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = tick && (cnt_q == '0);
  assign cnt_en = load || (tick && (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bop_combine.sv
module bop_combine #(
  parameter int ATT_W = 6,
  parameter int CAP_W = 5
) (
  input  logic [ATT_W-1:0] lim_att,
  input  logic [ATT_W-1:0] bop_att,
  input  logic [CAP_W-1:0] cap_code,
  input  logic [1:0]       atk_step,
  output logic [ATT_W-1:0] add_amt,
  output logic [ATT_W:0]   att_total
);
  logic [ATT_W:0] cap_units, sum, room, step_units;

  always_comb begin
    cap_units  = (ATT_W+1)'(cap_code) + (ATT_W+1)'(2);
    step_units = (ATT_W+1)'(atk_step) + (ATT_W+1)'(1);
    sum        = (ATT_W+1)'(lim_att) + (ATT_W+1)'(bop_att);
    room       = (sum < cap_units) ? (cap_units - sum) : '0;
    add_amt    = ATT_W'((room < step_units) ? room : step_units);
    att_total  = (sum > cap_units) ? cap_units : sum;
  end
endmodule

// File: rtl/bop_fsm.sv
module bop_fsm
  import bop_pkg::*;
#(
  parameter int          ATT_W        = 6,
  parameter int          CNT_W        = 21,
  parameter int unsigned TICKS_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             under,
  input  logic [ATT_W-1:0] add_amt,
  input  logic [2:0]       atk_rate,
  input  logic [2:0]       hold_sel,
  input  logic [2:0]       rls_rate,
  input  logic             sd_on_evt,
  input  logic             inf_hold,
  input  logic             hold_clr,
  input  logic             mute,
  input  logic             dev_off,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic [ATT_W-1:0] bop_att,
  output logic             evt_flag,
  output logic             sd_req
);
  bop_state_e       st_q, st_d;
  logic [ATT_W-1:0] att_q, att_d;
  logic             evt_q, evt_d, sd_q, sd_d;
  logic [CNT_W-1:0] atk_val, hold_val, rls_val;

  assign atk_val  = CNT_W'(less_one(32'd5 << atk_rate));
  assign hold_val = CNT_W'(less_one(hold_ms(hold_sel) * TICKS_PER_MS));
  assign rls_val  = CNT_W'(less_one(rls_ms(rls_rate) * TICKS_PER_MS));

  always_comb begin
    st_d     = st_q;
    att_d    = att_q;
    evt_d    = evt_q;
    sd_d     = sd_q;
    tmr_load = 1'b0;
    tmr_val  = atk_val;
    if (dev_off) begin
      st_d  = ST_IDLE;
      att_d = '0;
      evt_d = 1'b0;
      sd_d  = 1'b0;
    end else if (!en) begin
      st_d  = ST_IDLE;
      att_d = '0;
      evt_d = 1'b0;
    end else if (under && (st_q != ST_ATTACK)) begin
      // entry into attack from any other state
      st_d     = ST_ATTACK;
      att_d    = att_q + add_amt;
      evt_d    = 1'b1;
      sd_d     = sd_q | sd_on_evt;
      tmr_load = 1'b1;
      tmr_val  = atk_val;
    end else begin
      case (st_q)
        ST_ATTACK: begin
          if (!under) begin
            st_d     = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = hold_val;
          end else if (tmr_done) begin
            att_d    = att_q + add_amt;
            tmr_load = 1'b1;
            tmr_val  = atk_val;
          end
        end
        ST_HOLD: begin
          if (hold_clr || mute || (tmr_done && !inf_hold)) begin
            st_d     = ST_RELEASE;
            tmr_load = 1'b1;
            tmr_val  = rls_val;
          end
        end
        ST_RELEASE: begin
          if (tmr_done) begin
            if (att_q <= ATT_W'(1)) begin
              st_d  = ST_IDLE;
              att_d = '0;
              evt_d = 1'b0;
            end else begin
              att_d    = att_q - 1'b1;
              tmr_load = 1'b1;
              tmr_val  = rls_val;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      att_q <= '0;
      evt_q <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      att_q <= att_d;
      evt_q <= evt_d;
      sd_q  <= sd_d;
    end
  end

  assign bop_att  = att_q;
  assign evt_flag = evt_q;
  assign sd_req   = sd_q;
endmodule

// File: rtl/bop_ctrl.sv
module bop_ctrl #(
  parameter int          VB_W         = 8,
  parameter int          ATT_W        = 6,
  parameter int          CAP_W        = 5,
  parameter int unsigned TICKS_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             en,
  input  logic [VB_W-1:0]  vbat_code,
  input  logic [VB_W-1:0]  thr_code,
  input  logic [2:0]       atk_rate,
  input  logic [1:0]       atk_step,
  input  logic [2:0]       hold_sel,
  input  logic [2:0]       rls_rate,
  input  logic [CAP_W-1:0] cap_code,
  input  logic [ATT_W-1:0] lim_att,
  input  logic             sd_on_evt,
  input  logic             inf_hold,
  input  logic             hold_clr,
  input  logic             mute,
  input  logic             dev_off,
  output logic [ATT_W:0]   att_total,
  output logic [ATT_W-1:0] bop_att,
  output logic             sd_req,
  output logic             evt_flag
);
  localparam int CNT_W = $clog2(1500 * TICKS_PER_MS + 1);

  logic [1:0]       rst_sync;
  logic             rst_s;
  logic             under;
  logic [ATT_W-1:0] add_amt;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign under = (vbat_code < thr_code);

  bop_combine #(.ATT_W(ATT_W), .CAP_W(CAP_W)) u_comb (
    .lim_att  (lim_att),
    .bop_att  (bop_att),
    .cap_code (cap_code),
    .atk_step (atk_step),
    .add_amt  (add_amt),
    .att_total(att_total)
  );

  bop_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_s),
    .tick    (us_tick),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  bop_fsm #(.ATT_W(ATT_W), .CNT_W(CNT_W), .TICKS_PER_MS(TICKS_PER_MS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s),
    .en       (en),
    .under    (under),
    .add_amt  (add_amt),
    .atk_rate (atk_rate),
    .hold_sel (hold_sel),
    .rls_rate (rls_rate),
    .sd_on_evt(sd_on_evt),
    .inf_hold (inf_hold),
    .hold_clr (hold_clr),
    .mute     (mute),
    .dev_off  (dev_off),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .bop_att  (bop_att),
    .evt_flag (evt_flag),
    .sd_req   (sd_req)
  );
endmodule

// File: rtl/bop_ctrl_chk.sv
module bop_ctrl_chk #(
  parameter int VB_W  = 8,
  parameter int ATT_W = 6,
  parameter int CAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [VB_W-1:0]  vbat_code,
  input logic [VB_W-1:0]  thr_code,
  input logic [CAP_W-1:0] cap_code,
  input logic [ATT_W-1:0] lim_att,
  input logic             dev_off,
  input logic [ATT_W:0]   att_total,
  input logic [ATT_W-1:0] bop_att,
  input logic             sd_req,
  input logic             evt_flag
);
  logic [ATT_W:0] cap_u;
  assign cap_u = (ATT_W+1)'(cap_code) + (ATT_W+1)'(2);

  AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    att_total <= cap_u); // R4

  AST_FAST_ATTACK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dev_off && (vbat_code < thr_code) && ((ATT_W+1)'(lim_att) < cap_u))
    |=> (bop_att != '0)); // R2

  AST_NO_GROWTH_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vbat_code >= thr_code) |=> (bop_att <= $past(bop_att))); // R5

  AST_EVT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_att != '0) |-> evt_flag); // R6

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (bop_att == '0)); // R8

  AST_SD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_req && !dev_off) |=> sd_req); // R9
endmodule

bind bop_ctrl bop_ctrl_chk #(.VB_W(VB_W), .ATT_W(ATT_W), .CAP_W(CAP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .en       (en),
  .vbat_code(vbat_code),
  .thr_code (thr_code),
  .cap_code (cap_code),
  .lim_att  (lim_att),
  .dev_off  (dev_off),
  .att_total(att_total),
  .bop_att  (bop_att),
  .sd_req   (sd_req),
  .evt_flag (evt_flag)
);

// File: tb/tb_bop_ctrl.sv
`timescale 1ns/1ps
module tb_bop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       us_tick, en, sd_on_evt, inf_hold, hold_clr, mute, dev_off;
  logic [7:0] vbat_code, thr_code;
  logic [2:0] atk_rate, hold_sel, rls_rate;
  logic [1:0] atk_step;
  logic [4:0] cap_code;
  logic [5:0] lim_att;
  logic [6:0] att_total;
  logic [5:0] bop_att;
  logic       sd_req, evt_flag;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  always #5 clk = ~clk;

  bop_ctrl #(.TICKS_PER_MS(4)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .en(en),
    .vbat_code(vbat_code), .thr_code(thr_code), .atk_rate(atk_rate),
    .atk_step(atk_step), .hold_sel(hold_sel), .rls_rate(rls_rate),
    .cap_code(cap_code), .lim_att(lim_att), .sd_on_evt(sd_on_evt),
    .inf_hold(inf_hold), .hold_clr(hold_clr), .mute(mute), .dev_off(dev_off),
    .att_total(att_total), .bop_att(bop_att), .sd_req(sd_req), .evt_flag(evt_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // defaults: 2-unit steps, 5-tick attack, 40-tick hold, 40-tick release, cap 18
  task automatic start();
    @(negedge clk);
    rst_n = 1'b0; us_tick = 1'b1; en = 1'b1;
    vbat_code = 8'h30; thr_code = 8'h14;
    atk_rate = 3'd0; atk_step = 2'd1; hold_sel = 3'd1; rls_rate = 3'd0;
    cap_code = 5'd16; lim_att = 6'd0;
    sd_on_evt = 1'b0; inf_hold = 1'b0; hold_clr = 1'b0; mute = 1'b0; dev_off = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    start();
    chk("R6 reset evt", evt_flag, 0);
    chk("R8 reset bop", bop_att, 0);
    chk("R4 reset total", att_total, 0);
    chk("R9 reset sd", sd_req, 0);
  endtask

  task automatic t_threshold();
    start();
    vbat_code = 8'h14;
    cyc(20);
    chk("R1 equal is no dip", bop_att, 0);
    vbat_code = 8'h13;
    cyc(1);
    chk("R1 one below dips", bop_att, 2);
  endtask

  task automatic t_attack();
    start();
    vbat_code = 8'h10;
    cyc(1);
    chk("R2 first step", bop_att, 2);
    chk("R6 evt on attack", evt_flag, 1);
    cyc(3);
    chk("R3 interval not yet", bop_att, 2);
    cyc(2);
    chk("R3 second step", bop_att, 4);
  endtask

  task automatic t_step();
    start();
    atk_step = 2'd3; atk_rate = 3'd1;
    vbat_code = 8'h10;
    cyc(1);
    chk("R3 step code 3", bop_att, 4);
    cyc(9);
    chk("R3 10-tick wait", bop_att, 4);
    cyc(1);
    chk("R3 10-tick step", bop_att, 8);
  endtask

  task automatic t_cap();
    start();
    cap_code = 5'd10; lim_att = 6'd8;
    vbat_code = 8'h10;
    cyc(40);
    chk("R4 bop limited by share", bop_att, 4);
    chk("R4 total at cap", att_total, 12);
    lim_att = 6'd20;
    cyc(1);
    chk("R4 total clipped", att_total, 12);
  endtask

  task automatic t_release();
    start();
    vbat_code = 8'h10;
    cyc(1);
    vbat_code = 8'h30;
    cyc(70);
    chk("R5 held", bop_att, 2);
    chk("R6 evt in hold", evt_flag, 1);
    cyc(15);
    chk("R5 first release", bop_att, 1);
    cyc(40);
    chk("R5 released to zero", bop_att, 0);
    chk("R6 evt cleared", evt_flag, 0);
  endtask

  task automatic t_redip();
    start();
    vbat_code = 8'h10;
    cyc(1);
    vbat_code = 8'h30;
    cyc(10);
    vbat_code = 8'h10;
    cyc(1);
    chk("R7 redip in hold", bop_att, 4);
    vbat_code = 8'h30;
    cyc(50);
    chk("R7 in release", bop_att, 4);
    vbat_code = 8'h10;
    cyc(1);
    chk("R7 redip in release", bop_att, 6);
  endtask

  task automatic t_disable();
    start();
    en = 1'b0; lim_att = 6'd3;
    vbat_code = 8'h10;
    cyc(10);
    chk("R8 disabled bop", bop_att, 0);
    chk("R8 disabled total", att_total, 3);
    chk("R8 disabled evt", evt_flag, 0);
  endtask

  task automatic t_shutdown();
    start();
    sd_on_evt = 1'b1;
    vbat_code = 8'h10;
    cyc(1);
    chk("R9 sd raised", sd_req, 1);
    vbat_code = 8'h30;
    cyc(150);
    chk("R9 sd sticky", sd_req, 1);
    chk("R6 evt cleared idle", evt_flag, 0);
    vbat_code = 8'h10;
    cyc(3);
    dev_off = 1'b1;
    cyc(1);
    chk("R9 sd cleared", sd_req, 0);
    chk("R9 off clears att", bop_att, 0);
    dev_off = 1'b0;
    vbat_code = 8'h30;
    cyc(1);
  endtask

  task automatic t_infhold(input bit use_mute);
    start();
    inf_hold = 1'b1;
    vbat_code = 8'h10;
    cyc(1);
    vbat_code = 8'h30;
    cyc(300);
    chk("R10 infinite hold", bop_att, 2);
    if (use_mute) mute = 1'b1; else hold_clr = 1'b1;
    cyc(1);
    hold_clr = 1'b0;
    chk("R10 after clear", bop_att, 2);
    cyc(45);
    chk(use_mute ? "R10 mute release" : "R10 clear release", bop_att, 1);
    mute = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_threshold();
    t_attack();
    t_step();
    t_cap();
    t_release();
    t_redip();
    t_disable();
    t_shutdown();
    t_infhold(1'b0);
    t_infhold(1'b1);
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule